// File: doc/BRIEF.md
# License-Gated Usage Allowance Controller

This block sits beside a region of protected logic and decides whether that logic may run. It builds a fresh 128-bit challenge value (the nonce) from random bits supplied on a port. The random word for each gathering cycle is the XOR of several independent entropy slices. Once the nonce is complete it is announced to the outside world with a one-cycle strobe. An external signature checker verifies a license against a key that the block never sees, and presents its pass/fail verdict together with the license. The license carries a nonce copy and a credit amount.

A license adds its credit to a usage allowance only when three things hold: the signature check passed, a nonce is outstanding, and the license's nonce equals that outstanding nonce. Every license handshake retires the nonce, whether the license is accepted or rejected, and generation of a new nonce starts. An old license therefore never earns credit twice. Each authorised operation consumes one credit. While the allowance is zero the protected-logic enable is low, and operation requests are refused with an error pulse.

Top module: `lg_license_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the allowance is 0, prot_en is low, status is 0 (idle), and lic_accept, lic_reject, op_grant, op_err and nonce_valid are low.
- R2: A license handshake (lic_valid and lic_ready both high at a clock edge) is accepted only if sig_ok is high, a nonce is outstanding, and lic_nonce equals the nonce output. Otherwise it is rejected. Exactly one of lic_accept and lic_reject pulses for one cycle after the handshake edge.
- R3: An accepted license adds lic_credit to the allowance, and the new value shows on the allowance output after the same edge that raises lic_accept.
- R4: An op_req sampled while the allowance is nonzero raises op_grant for one cycle after that edge and lowers the allowance by one.
- R5: prot_en is high exactly when the allowance is nonzero. It falls only at the edge that grants the last credit.
- R6: Every license handshake, accepted or rejected, retires the outstanding nonce. A later copy of an already used license is rejected and adds no credit.
- R7: An op_req sampled while the allowance is zero raises op_err for one cycle, and the allowance stays at 0 (it never wraps).
- R8: A license presented while no nonce is outstanding is rejected, adds no credit, and restarts nonce gathering from the beginning.
- R9: The allowance saturates at 2^ALW_W-1 (1023 by default) instead of overflowing.
- R10: When a license acceptance and an op_req share an edge, the grant or error is decided on the allowance held before that edge. The new allowance is then old + credit - grant, clamped to the maximum.
- R11: status encodes 0 = idle (allowance zero, never enabled, no nonce outstanding), 1 = awaiting license (allowance zero, never enabled, nonce outstanding), 2 = enabled (allowance nonzero), 3 = halted (allowance zero after having been nonzero).
- R12: The nonce is gathered over NONCE_W/WORD_W cycles (4 by default). On each cycle, the XOR of the NUM_SRC WORD_W-bit slices of rng_bits (bits 31:0 XOR bits 63:32 by default) shifts in at the least significant end while older words move up. The nonce output shows the gathering register, which is held once it is complete. nonce_valid pulses for one cycle at completion.
- R13: lic_ready is high from the first clock edge after reset release onward.

Both license checks and operations are handled at the same clock edge without blocking each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rng_bits | input | NUM_SRC*WORD_W | Raw entropy slices, XOR-combined per cycle |
| nonce | output | NONCE_W | Current nonce / gathering register |
| nonce_valid | output | 1 | One-cycle strobe when a new nonce is complete |
| lic_valid | input | 1 | License presented |
| lic_ready | output | 1 | Block can take a license |
| lic_nonce | input | NONCE_W | Nonce copy carried by the license |
| lic_credit | input | CREDIT_W | Credit carried by the license |
| sig_ok | input | 1 | External signature verdict for the presented license |
| lic_accept | output | 1 | One-cycle pulse: license accepted |
| lic_reject | output | 1 | One-cycle pulse: license rejected |
| op_req | input | 1 | Request to perform one authorised operation |
| op_grant | output | 1 | One-cycle pulse: operation granted, one credit used |
| op_err | output | 1 | One-cycle pulse: operation refused, allowance empty |
| allowance | output | ALW_W | Remaining credit |
| prot_en | output | 1 | Enable to the protected logic |
| status | output | 2 | Controller state code (see R11) |

## Verification
The interesting coincidence is a license acceptance landing on the same edge as an operation request. The block must then decide the grant on the pre-credit allowance while still applying both the addition and the decrement. The bench provokes this twice. First, with an empty allowance, the request must yield op_err and the full credit must remain. Second, with a nonzero allowance, the request must yield op_grant and credit minus one must be added. A long randomized phase overlaps requests and licenses freely, and a behavioural model checks every output on every clock.

// File: rtl/lg_pkg.sv
package lg_pkg;

   typedef enum logic [1:0] {
      LG_IDLE    = 2'd0,
      LG_AWAIT   = 2'd1,
      LG_ENABLED = 2'd2,
      LG_HALTED  = 2'd3
   } lg_status_e;

endpackage

// File: rtl/lg_entropy_mix.sv
module lg_entropy_mix #(
   parameter int WORD_W  = 32,
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC*WORD_W-1:0] raw,
   output logic [WORD_W-1:0]         word
);

   generate
      if (NUM_SRC == 1) begin : g_single
         assign word = raw;
      end else begin : g_xor
         always_comb begin
            word = '0;
            for (int s = 0; s < NUM_SRC; s++) begin
               word = word ^ raw[s*WORD_W +: WORD_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lg_nonce_gen.sv
module lg_nonce_gen #(
   parameter int NONCE_W = 128,
   parameter int WORD_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WORD_W-1:0]  word_in,
   input  logic               retire,
   output logic [NONCE_W-1:0] nonce,
   output logic               outstanding,
   output logic               ready_pulse
);

   localparam int WORDS = NONCE_W / WORD_W;
   localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

   logic [NONCE_W-1:0] acc_q;
   logic [NONCE_W-1:0] acc_shift;
   logic [CNT_W-1:0]   cnt_q;
   logic               out_q;
   logic               pulse_q;

   generate
      if (WORDS == 1) begin : g_one_word
         assign acc_shift = word_in;
      end else begin : g_multi_word
         assign acc_shift = {acc_q[NONCE_W-WORD_W-1:0], word_in};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         cnt_q   <= '0;
         out_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (retire) begin
            out_q <= 1'b0;
            cnt_q <= '0;
         end else if (!out_q) begin
            acc_q <= acc_shift;
            if (cnt_q == LAST) begin
               out_q   <= 1'b1;
               pulse_q <= 1'b1;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign nonce       = acc_q;
   assign outstanding = out_q;
   assign ready_pulse = pulse_q;

endmodule

// File: rtl/lg_license_check.sv
module lg_license_check #(
   parameter int NONCE_W = 128
) (
   input  logic               fire,
   input  logic               outstanding,
   input  logic               sig_ok,
   input  logic [NONCE_W-1:0] lic_nonce,
   input  logic [NONCE_W-1:0] cur_nonce,
   output logic               take,
   output logic               refuse
);

   logic bound;

   always_comb begin
      bound  = outstanding && (lic_nonce == cur_nonce);
      take   = fire && sig_ok && bound;
      refuse = fire && !(sig_ok && bound);
   end

endmodule

// File: rtl/lg_allowance.sv
module lg_allowance #(
   parameter int ALW_W    = 10,
   parameter int CREDIT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                add_en,
   input  logic [CREDIT_W-1:0] add_val,
   input  logic                op_req,
   output logic [ALW_W-1:0]    level,
   output logic                nonzero,
   output logic                grant,
   output logic                err
);

   localparam int SUM_W = ALW_W + 1;
   localparam logic [ALW_W-1:0] MAX_LVL = '1;

   logic [ALW_W-1:0] lvl_q;
   logic             grant_q;
   logic             err_q;
   logic             dec;
   logic [SUM_W-1:0] add_ext;
   logic [SUM_W-1:0] sum;
   logic [ALW_W-1:0] lvl_d;

   always_comb begin
      dec     = op_req && (lvl_q != '0);
      add_ext = add_en ? SUM_W'(add_val) : '0;
      sum     = {1'b0, lvl_q} + add_ext - SUM_W'(dec);
      lvl_d   = sum[ALW_W] ? MAX_LVL : sum[ALW_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         grant_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         lvl_q   <= lvl_d;
         grant_q <= dec;
         err_q   <= op_req && (lvl_q == '0);
      end
   end

   assign level   = lvl_q;
   assign nonzero = (lvl_q != '0);
   assign grant   = grant_q;
   assign err     = err_q;

endmodule

// File: rtl/lg_license_gate.sv
module lg_license_gate #(
   parameter int NONCE_W  = 128,
   parameter int WORD_W   = 32,
   parameter int NUM_SRC  = 2,
   parameter int CREDIT_W = 8,
   parameter int ALW_W    = 10
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC*WORD_W-1:0] rng_bits,
   output logic [NONCE_W-1:0]        nonce,
   output logic                      nonce_valid,
   input  logic                      lic_valid,
   output logic                      lic_ready,
   input  logic [NONCE_W-1:0]        lic_nonce,
   input  logic [CREDIT_W-1:0]       lic_credit,
   input  logic                      sig_ok,
   output logic                      lic_accept,
   output logic                      lic_reject,
   input  logic                      op_req,
   output logic                      op_grant,
   output logic                      op_err,
   output logic [ALW_W-1:0]          allowance,
   output logic                      prot_en,
   output logic [1:0]                status
);

   import lg_pkg::*;

   generate
      if (NONCE_W % WORD_W != 0) begin : g_bad_word
         $error("lg_license_gate: NONCE_W must be a multiple of WORD_W");
      end
      if (NUM_SRC < 1) begin : g_bad_src
         $error("lg_license_gate: NUM_SRC must be at least 1");
      end
      if (ALW_W < CREDIT_W) begin : g_bad_alw
         $error("lg_license_gate: ALW_W must be at least CREDIT_W");
      end
   endgenerate

   logic [WORD_W-1:0] mixed;
   logic              outstanding;
   logic              fire;
   logic              take;
   logic              refuse;
   logic              ready_q;
   logic              accept_q;
   logic              reject_q;
   logic              ever_q;
   logic              nonzero;
   lg_status_e        status_s;

   assign fire = lic_valid && ready_q;

   lg_entropy_mix #(.WORD_W(WORD_W), .NUM_SRC(NUM_SRC)) u_mix (
      .raw  (rng_bits),
      .word (mixed)
   );

   lg_nonce_gen #(.NONCE_W(NONCE_W), .WORD_W(WORD_W)) u_nonce (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_in     (mixed),
      .retire      (fire),
      .nonce       (nonce),
      .outstanding (outstanding),
      .ready_pulse (nonce_valid)
   );

   lg_license_check #(.NONCE_W(NONCE_W)) u_check (
      .fire        (fire),
      .outstanding (outstanding),
      .sig_ok      (sig_ok),
      .lic_nonce   (lic_nonce),
      .cur_nonce   (nonce),
      .take        (take),
      .refuse      (refuse)
   );

   lg_allowance #(.ALW_W(ALW_W), .CREDIT_W(CREDIT_W)) u_alw (
      .clk     (clk),
      .rst_n   (rst_n),
      .add_en  (take),
      .add_val (lic_credit),
      .op_req  (op_req),
      .level   (allowance),
      .nonzero (nonzero),
      .grant   (op_grant),
      .err     (op_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q  <= 1'b0;
         accept_q <= 1'b0;
         reject_q <= 1'b0;
         ever_q   <= 1'b0;
      end else begin
         ready_q  <= 1'b1;
         accept_q <= take;
         reject_q <= refuse;
         ever_q   <= ever_q | nonzero;
      end
   end

   always_comb begin
      if (nonzero)          status_s = LG_ENABLED;
      else if (ever_q)      status_s = LG_HALTED;
      else if (outstanding) status_s = LG_AWAIT;
      else                  status_s = LG_IDLE;
   end

   assign lic_ready  = ready_q;
   assign lic_accept = accept_q;
   assign lic_reject = reject_q;
   assign prot_en    = nonzero;
   assign status     = status_s;

endmodule

// File: rtl/lg_license_gate_chk.sv
module lg_license_gate_chk #(
   parameter int ALW_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lic_valid,
   input logic             lic_ready,
   input logic             lic_accept,
   input logic             lic_reject,
   input logic             op_req,
   input logic             op_grant,
   input logic             op_err,
   input logic             nonce_valid,
   input logic [ALW_W-1:0] allowance,
   input logic             prot_en
);

   a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(lic_accept && lic_reject));

   a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (lic_valid && lic_ready) |=> (lic_accept || lic_reject));

   a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      op_grant |-> $past(op_req));

   a_r4_grant_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_grant && op_err));

   a_r7_err_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
      op_err |-> ($past(allowance) == '0));

   a_r3_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_grant && !lic_accept) |-> (allowance == $past(allowance)));

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (lic_accept && !op_grant) |-> (allowance >= $past(allowance)));

   a_r5_fall_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prot_en) |-> op_grant);

   a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      nonce_valid |=> !nonce_valid);

endmodule

bind lg_license_gate lg_license_gate_chk #(.ALW_W(ALW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lic_valid   (lic_valid),
   .lic_ready   (lic_ready),
   .lic_accept  (lic_accept),
   .lic_reject  (lic_reject),
   .op_req      (op_req),
   .op_grant    (op_grant),
   .op_err      (op_err),
   .nonce_valid (nonce_valid),
   .allowance   (allowance),
   .prot_en     (prot_en)
);

// File: tb/lg_license_gate_tb.sv
`timescale 1ns/1ps
module lg_license_gate_tb;

   localparam int MAXA = 1023;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [63:0]  rng_bits = '0;
   logic [127:0] nonce;
   logic         nonce_valid;
   logic         lic_valid = 1'b0;
   logic         lic_ready;
   logic [127:0] lic_nonce = '0;
   logic [7:0]   lic_credit = '0;
   logic         sig_ok = 1'b0;
   logic         lic_accept, lic_reject;
   logic         op_req = 1'b0;
   logic         op_grant, op_err;
   logic [9:0]   allowance;
   logic         prot_en;
   logic [1:0]   status;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;
   bit model_on = 0;

   lg_license_gate u_dut (
      .clk(clk), .rst_n(rst_n), .rng_bits(rng_bits), .nonce(nonce),
      .nonce_valid(nonce_valid), .lic_valid(lic_valid), .lic_ready(lic_ready),
      .lic_nonce(lic_nonce), .lic_credit(lic_credit), .sig_ok(sig_ok),
      .lic_accept(lic_accept), .lic_reject(lic_reject), .op_req(op_req),
      .op_grant(op_grant), .op_err(op_err), .allowance(allowance),
      .prot_en(prot_en), .status(status)
   );

   always #10 clk = ~clk;

   always @(negedge clk) rng_bits <= {$urandom, $urandom};

   // behavioural reference
   logic [127:0] m_acc;
   int  m_cnt, m_alw;
   bit  m_out, m_ever, m_nv, m_ready, m_accept, m_reject, m_grant, m_err;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = '0; m_cnt = 0; m_alw = 0; m_out = 0; m_ever = 0; m_nv = 0;
         m_ready = 0; m_accept = 0; m_reject = 0; m_grant = 0; m_err = 0;
      end else begin
         bit fire, good;
         int nw;
         fire = lic_valid && m_ready;
         good = m_out && sig_ok && (lic_nonce == m_acc);
         m_accept = fire && good;
         m_reject = fire && !good;
         m_grant = op_req && (m_alw > 0);
         m_err   = op_req && (m_alw == 0);
         nw = m_alw + (m_accept ? int'(lic_credit) : 0) - (m_grant ? 1 : 0);
         if (nw > MAXA) nw = MAXA;
         m_alw = nw;
         if (nw > 0) m_ever = 1;
         m_nv = 0;
         if (fire) begin
            m_out = 0; m_cnt = 0;
         end else if (!m_out) begin
            m_acc = {m_acc[95:0], rng_bits[31:0] ^ rng_bits[63:32]};
            if (m_cnt == 3) begin m_out = 1; m_nv = 1; m_cnt = 0; end
            else m_cnt++;
         end
         m_ready = 1;
      end
   end

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_status();
      if (m_alw > 0) return 2;
      if (m_ever) return 3;
      if (m_out) return 1;
      return 0;
   endfunction

   always @(posedge clk) begin
      #5;
      if (rst_n && model_on && !done) begin
         check("R2 lic_accept",  lic_accept, m_accept);
         check("R2 lic_reject",  lic_reject, m_reject);
         check("R3 allowance",   allowance, m_alw);
         check("R4 op_grant",    op_grant, m_grant);
         check("R7 op_err",      op_err, m_err);
         check("R5 prot_en",     prot_en, m_alw > 0);
         check("R11 status",     status, exp_status());
         check("R12 nonce",      nonce, m_acc);
         check("R12 nonce_valid", nonce_valid, m_nv);
         check("R13 lic_ready",  lic_ready, m_ready);
      end
   end

   task automatic wait_nonce(output logic [127:0] n);
      @(negedge clk);
      while (!m_out) @(negedge clk);
      n = nonce;
   endtask

   task automatic send_lic(input logic [127:0] n, input int cr, input bit ok, input bit op);
      @(negedge clk);
      lic_valid = 1; lic_nonce = n; lic_credit = 8'(cr); sig_ok = ok; op_req = op;
      @(negedge clk);
      lic_valid = 0; sig_ok = 0; op_req = 0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [127:0] n0, n1;
      repeat (3) @(negedge clk);
      // R1 reset values
      check("R1 alw", allowance, 0);
      check("R1 en", prot_en, 0);
      check("R1 status", status, 0);
      check("R1 pulses", {lic_accept, lic_reject, op_grant, op_err, nonce_valid}, 0);
      rst_n = 1; model_on = 1;
      // R7 request on empty allowance
      @(negedge clk); op_req = 1;
      @(negedge clk); op_req = 0;
      check("R7 err", op_err, 1);
      check("R7 stays zero", allowance, 0);
      wait_nonce(n0);
      check("R11 awaiting", status, 1);
      // R2 R3 R5 valid license
      send_lic(n0, 3, 1, 0);
      check("R2 accept", lic_accept, 1);
      check("R3 credit", allowance, 3);
      check("R5 enable", prot_en, 1);
      // R8 license with no nonce outstanding
      send_lic(n0, 9, 1, 0);
      check("R8 reject", lic_reject, 1);
      check("R8 no credit", allowance, 3);
      // R2 bad signature
      wait_nonce(n1);
      send_lic(n1, 9, 0, 0);
      check("R2 bad sig", lic_reject, 1);
      // R2 wrong nonce
      wait_nonce(n1);
      send_lic(n1 ^ 128'h1, 9, 1, 0);
      check("R2 wrong nonce", lic_reject, 1);
      // R6 replay
      wait_nonce(n1);
      send_lic(n0, 9, 1, 0);
      check("R6 replay", lic_reject, 1);
      check("R6 no credit", allowance, 3);
      // R4 drain
      @(negedge clk); op_req = 1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R4 grant", op_grant, 1);
         check("R4 dec", allowance, 2 - i);
      end
      op_req = 0;
      check("R5 halted en", prot_en, 0);
      check("R11 halted", status, 3);
      // R10 coincidences
      wait_nonce(n1);
      send_lic(n1, 2, 1, 1);
      check("R10 err on empty", op_err, 1);
      check("R10 full credit", allowance, 2);
      wait_nonce(n1);
      send_lic(n1, 5, 1, 1);
      check("R10 grant", op_grant, 1);
      check("R10 net", allowance, 6);
      // R9 saturation
      for (int i = 0; i < 5; i++) begin
         wait_nonce(n1);
         send_lic(n1, 255, 1, 0);
      end
      check("R9 saturate", allowance, MAXA);
      // random mix
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk);
         op_req = ($urandom % 10) < 3;
         if (m_out && ($urandom % 6 == 0) || ($urandom % 40 == 0)) begin
            lic_valid = 1;
            lic_nonce = ($urandom % 4 == 0) ? {$urandom, $urandom, $urandom, $urandom} : nonce;
            lic_credit = 8'($urandom % 12);
            sig_ok = ($urandom % 5) != 0;
         end else begin
            lic_valid = 0; sig_ok = 0;
         end
      end
      @(negedge clk); lic_valid = 0; op_req = 0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule